// File: doc/BRIEF.md
# Fine-Grained Label Egress Decapsulator

This block sits on one output port of a routing switch. It takes the inner frame that follows the outer routing header, byte by byte, on an AXI4-Stream input. It produces the native Ethernet frame for that port on an AXI4-Stream output. The inner frame starts with the destination and source MAC addresses (bytes 0..11). Bytes 12..13 then carry one of two markers:

- 0x8100 marks a frame labeled with an ordinary 12-bit VLAN tag.
- 0x893B marks a frame carrying a 24-bit fine-grained label. The label is split across two 16-bit words, each preceded by 0x893B.

The port runs in one of two modes. In VLAN-label mode, VLAN-tagged frames pass untouched and fine-grained frames are discarded. In fine-grained mode, the 24-bit label is rebuilt and compared with a small table of configured labels. A matching frame has its 8 label bytes replaced by a normal 802.1Q tag. The tag takes its VLAN ID from the matching table entry and its priority and drop-eligible bit from the low label word. A port set to strip tagging removes the label bytes with no tag put back.

The block stores the header bytes until it has decided what to do with the frame. It then replays the kept bytes and passes the payload straight through. Frames it refuses are drained from the input without any output.

Top module: `fgl_label_egress`

## Requirements
- R1: Bytes 12..13 of the inner frame select the class: 0x8100 is VLAN-labeled, 0x893B is fine-grained labeled, and any other value causes the whole frame to be dropped in both port modes.
- R2: With portFgl=0 and portStrip=0, a VLAN-labeled frame leaves byte-for-byte unchanged, and a fine-grained frame produces no output at all.
- R3: With portFgl=1, the label is {byte14[3:0], byte15, byte18[3:0], byte19}. A frame passes only if this full 24-bit value equals the label of a table entry whose valid bit is set. A match on only the upper or only the lower 12 bits, or a match on an entry whose valid bit is clear, drops the frame.
- R4: With portFgl=1, a VLAN-labeled frame is dropped, and a fine-grained frame whose bytes 16..17 are not 0x893B is dropped.
- R5: A passing fine-grained frame with portStrip=0 is output as bytes 0..11, then 0x81, 0x00, {byte18[7:4], vid[11:8]}, vid[7:0], then the payload from byte 20 on. This makes it 4 bytes shorter than the input. vid comes from the lowest-index valid entry that matches.
- R6: With portStrip=1, the label or tag bytes are removed. A passing fine-grained frame becomes 8 bytes shorter and a passing VLAN frame becomes 4 bytes shorter; all other bytes are unchanged.
- R7: A frame whose tlast arrives before its label bytes are complete produces no output, and the following frame is handled normally.
- R8: A passing frame with no payload bytes carries tlast on the last byte of its rebuilt header, and on no other byte.
- R9: While output valid is high and output ready is low, the output byte and valid do not change, and every byte of the frame is delivered in order under any ready pattern.
- R10: After reset, output valid is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sAxisTdata | input | 8 | Inner frame byte |
| sAxisTvalid | input | 1 | Input byte valid |
| sAxisTlast | input | 1 | Last byte of the inner frame |
| sAxisTready | output | 1 | Input byte accepted |
| mAxisTdata | output | 8 | Native frame byte |
| mAxisTvalid | output | 1 | Output byte valid |
| mAxisTlast | output | 1 | Last byte of the native frame |
| mAxisTready | input | 1 | Downstream ready |
| portFgl | input | 1 | 1 = fine-grained mode, 0 = VLAN-label mode |
| portStrip | input | 1 | 1 = emit frames without any VLAN tag |
| cfgValid | input | NUM_LABELS | Valid bit for each label table entry |
| cfgLabel | input | NUM_LABELS*24 | Entry labels, entry i at bits [24i+23:24i] |
| cfgVid | input | NUM_LABELS*12 | Output VLAN ID of each entry, entry i at bits [12i+11:12i] |

## Verification
Fine-grained frames are sent with a full-label match, a match on the upper half only, a match on the lower half only, and a match on an entry whose valid bit is clear. Only the first may come out, which separates a true 24-bit compare from a partial one. A label present in two entries with different VLAN IDs, and a transport priority that differs from the low-word priority, show which entry and which priority nibble end up in the rebuilt tag. The same frames are also sent through a VLAN-mode port, through a stripping port, as runt and payload-free frames, and under a stalling downstream. These runs show the discard rules, the two length reductions, tlast placement and data holding under backpressure.

// File: rtl/fgl_decap_pkg.sv
package fgl_decap_pkg;
  localparam int LABEL_W = 24;
  localparam int VID_W = 12;
  localparam int HDR_MAX = 20;
  localparam logic [15:0] ETYPE_VLAN = 16'h8100;
  localparam logic [15:0] ETYPE_FGL = 16'h893B;

  typedef enum logic [1:0] {CLS_OTHER, CLS_VL, CLS_FGL} frameClsT;

  typedef struct packed {
    logic store;
    logic restart;
    logic lookup;
    logic emitStep;
  } pathCtrlT;
endpackage

// File: rtl/fgl_label_cam.sv
module fgl_label_cam
  import fgl_decap_pkg::*;
#(
  parameter int NUM_LABELS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lookup,
  input  logic [LABEL_W-1:0]          key,
  input  logic [NUM_LABELS-1:0]       cfgValid,
  input  logic [NUM_LABELS*LABEL_W-1:0] cfgLabel,
  input  logic [NUM_LABELS*VID_W-1:0] cfgVid,
  output logic                        hitQ,
  output logic [VID_W-1:0]            vidQ
);
  logic [NUM_LABELS-1:0] matchVec;
  logic [VID_W-1:0] vidSel;

  for (genvar g = 0; g < NUM_LABELS; g++) begin : g_cmp
    assign matchVec[g] = cfgValid[g] && (cfgLabel[g*LABEL_W +: LABEL_W] == key);
  end

  // Walk from the top so the lowest matching index is the one that remains.
  always_comb begin
    vidSel = '0;
    for (int i = NUM_LABELS - 1; i >= 0; i--) begin
      if (matchVec[i]) vidSel = cfgVid[i*VID_W +: VID_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= 1'b0;
      vidQ <= '0;
    end else if (lookup) begin
      hitQ <= |matchVec;
      vidQ <= vidSel;
    end
  end

  // R3: a hit can only appear right after a lookup strobe
  p_hit_after_lookup_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitQ) |-> $past(lookup));
endmodule

// File: rtl/fgl_decap_path.sv
module fgl_decap_path
  import fgl_decap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  pathCtrlT           ctrl,
  input  logic [7:0]         sTdata,
  input  logic               portStrip,
  input  logic [VID_W-1:0]   vidQ,
  output logic               hdrDone,
  output frameClsT           cls,
  output logic               fglSecondOk,
  output logic [LABEL_W-1:0] label,
  output logic [7:0]         emitByte,
  output logic               emitFinal
);
  localparam logic [4:0] MAC_BYTES = 5'd12;
  localparam logic [4:0] TAG_END = 5'd16;

  logic [7:0] hdr [HDR_MAX];
  logic [4:0] idx;
  logic [4:0] emitCnt;
  logic [15:0] etypeNow;
  logic [4:0] need;
  logic [4:0] emitLen;

  assign etypeNow = (idx == 5'd13) ? {hdr[12], sTdata} : {hdr[12], hdr[13]};

  always_comb begin
    if (etypeNow == ETYPE_VLAN) need = 5'd16;
    else if (etypeNow == ETYPE_FGL) need = 5'd20;
    else need = 5'd14;
  end

  assign hdrDone = (idx == need - 5'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
      emitCnt <= '0;
      for (int i = 0; i < HDR_MAX; i++) hdr[i] <= '0;
    end else if (ctrl.restart) begin
      idx <= '0;
      emitCnt <= '0;
    end else begin
      if (ctrl.store && idx < 5'(HDR_MAX)) begin
        hdr[idx] <= sTdata;
        idx <= idx + 5'd1;
      end
      if (ctrl.emitStep) emitCnt <= emitCnt + 5'd1;
    end
  end

  always_comb begin
    if ({hdr[12], hdr[13]} == ETYPE_VLAN) cls = CLS_VL;
    else if ({hdr[12], hdr[13]} == ETYPE_FGL) cls = CLS_FGL;
    else cls = CLS_OTHER;
  end

  assign fglSecondOk = ({hdr[16], hdr[17]} == ETYPE_FGL);
  assign label = {hdr[14][3:0], hdr[15], hdr[18][3:0], hdr[19]};

  assign emitLen = portStrip ? MAC_BYTES : TAG_END;
  assign emitFinal = (emitCnt == emitLen - 5'd1);

  always_comb begin
    if (emitCnt < MAC_BYTES || cls == CLS_VL) begin
      emitByte = hdr[emitCnt];
    end else begin
      case (emitCnt)
        5'd12:   emitByte = ETYPE_VLAN[15:8];
        5'd13:   emitByte = ETYPE_VLAN[7:0];
        5'd14:   emitByte = {hdr[18][7:4], vidQ[11:8]};
        default: emitByte = vidQ[7:0];
      endcase
    end
  end

  // R5: the replay counter never runs past the rebuilt tag
  p_emit_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emitStep |-> emitCnt < TAG_END);
  // R7: a restart always leaves the capture index at zero
  p_idx_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restart |=> idx == 5'd0);
endmodule

// File: rtl/fgl_decap_ctrl.sv
module fgl_decap_ctrl
  import fgl_decap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sTvalid,
  input  logic      sTlast,
  input  logic      mTready,
  input  logic      portFgl,
  input  logic      hdrDone,
  input  frameClsT  cls,
  input  logic      fglSecondOk,
  input  logic      hitQ,
  input  logic      emitFinal,
  output pathCtrlT  ctrl,
  output logic      sTready,
  output logic      mTvalid,
  output logic      mTlastEmit,
  output logic      emitting
);
  typedef enum logic [2:0] {S_HDR, S_LOOK, S_CHECK, S_EMIT, S_PASS, S_DROP} stateT;

  stateT state, stateNxt;
  logic lastSeen;
  logic keep;

  assign keep = (cls == CLS_VL && !portFgl) ||
                (cls == CLS_FGL && portFgl && fglSecondOk && hitQ);

  always_comb begin
    stateNxt = state;
    ctrl = '0;
    sTready = 1'b0;
    mTvalid = 1'b0;
    emitting = 1'b0;
    unique case (state)
      S_HDR: begin
        sTready = 1'b1;
        if (sTvalid) begin
          if (hdrDone) begin
            ctrl.store = 1'b1;
            stateNxt = S_LOOK;
          end else if (sTlast) begin
            ctrl.restart = 1'b1;
          end else begin
            ctrl.store = 1'b1;
          end
        end
      end
      S_LOOK: begin
        ctrl.lookup = 1'b1;
        stateNxt = S_CHECK;
      end
      S_CHECK: begin
        if (keep) stateNxt = S_EMIT;
        else if (lastSeen) begin
          ctrl.restart = 1'b1;
          stateNxt = S_HDR;
        end else stateNxt = S_DROP;
      end
      S_EMIT: begin
        mTvalid = 1'b1;
        emitting = 1'b1;
        if (mTready) begin
          ctrl.emitStep = 1'b1;
          if (emitFinal) begin
            if (lastSeen) begin
              ctrl.restart = 1'b1;
              stateNxt = S_HDR;
            end else stateNxt = S_PASS;
          end
        end
      end
      S_PASS: begin
        mTvalid = sTvalid;
        sTready = mTready;
        if (sTvalid && mTready && sTlast) begin
          ctrl.restart = 1'b1;
          stateNxt = S_HDR;
        end
      end
      default: begin
        sTready = 1'b1;
        if (sTvalid && sTlast) begin
          ctrl.restart = 1'b1;
          stateNxt = S_HDR;
        end
      end
    endcase
  end

  assign mTlastEmit = lastSeen && emitFinal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_HDR;
      lastSeen <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_HDR && sTvalid && hdrDone) lastSeen <= sTlast;
    end
  end

  // R3: the keep decision is only taken one cycle after the lookup
  p_check_after_look_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == S_CHECK |-> $past(state) == S_LOOK);
  // R2: a VLAN-mode port never replays a fine-grained header
  p_vl_port_blocks_fgl_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EMIT && cls == CLS_FGL) |-> portFgl);
  // R9: a stalled replay stays in place
  p_emit_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EMIT && !mTready) |=> state == S_EMIT);
endmodule

// File: rtl/fgl_label_egress.sv
module fgl_label_egress
  import fgl_decap_pkg::*;
#(
  parameter int NUM_LABELS = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    sAxisTdata,
  input  logic                          sAxisTvalid,
  input  logic                          sAxisTlast,
  output logic                          sAxisTready,
  output logic [7:0]                    mAxisTdata,
  output logic                          mAxisTvalid,
  output logic                          mAxisTlast,
  input  logic                          mAxisTready,
  input  logic                          portFgl,
  input  logic                          portStrip,
  input  logic [NUM_LABELS-1:0]         cfgValid,
  input  logic [NUM_LABELS*24-1:0]      cfgLabel,
  input  logic [NUM_LABELS*12-1:0]      cfgVid
);
  pathCtrlT ctrl;
  frameClsT cls;
  logic hdrDone, fglSecondOk, emitFinal, hitQ, mTlastEmit, emitting;
  logic [LABEL_W-1:0] label;
  logic [VID_W-1:0] vidQ;
  logic [7:0] emitByte;

  fgl_decap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .sTvalid(sAxisTvalid), .sTlast(sAxisTlast), .mTready(mAxisTready),
    .portFgl(portFgl), .hdrDone(hdrDone), .cls(cls), .fglSecondOk(fglSecondOk),
    .hitQ(hitQ), .emitFinal(emitFinal), .ctrl(ctrl),
    .sTready(sAxisTready), .mTvalid(mAxisTvalid),
    .mTlastEmit(mTlastEmit), .emitting(emitting)
  );

  fgl_decap_path i_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sTdata(sAxisTdata),
    .portStrip(portStrip), .vidQ(vidQ), .hdrDone(hdrDone), .cls(cls),
    .fglSecondOk(fglSecondOk), .label(label), .emitByte(emitByte),
    .emitFinal(emitFinal)
  );

  fgl_label_cam #(.NUM_LABELS(NUM_LABELS)) i_cam (
    .clk(clk), .rstN(rstN), .lookup(ctrl.lookup), .key(label),
    .cfgValid(cfgValid), .cfgLabel(cfgLabel), .cfgVid(cfgVid),
    .hitQ(hitQ), .vidQ(vidQ)
  );

  assign mAxisTdata = emitting ? emitByte : sAxisTdata;
  assign mAxisTlast = emitting ? mTlastEmit : sAxisTlast;

  // R9: replayed header bytes hold under backpressure
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (emitting && !mAxisTready) |=> mAxisTvalid && $stable(mAxisTdata));
endmodule

// File: tb/test_fgl_label_egress.sv
`timescale 1ns/1ps
module test_fgl_label_egress;
  typedef logic [7:0] byteQ[$];
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sTdata = '0;
  logic sTvalid = 1'b0, sTlast = 1'b0, sTready;
  logic [7:0] mTdata;
  logic mTvalid, mTlast;
  logic mTready = 1'b1;
  logic portFgl = 1'b0, portStrip = 1'b0;
  logic [NL-1:0] cfgValid = '0;
  logic [NL*24-1:0] cfgLabel = '0;
  logic [NL*12-1:0] cfgVid = '0;

  int checks = 0;
  int errors = 0;
  byteQ outQ;
  int lastCount;
  int lastPos;

  always #4 clk = ~clk;

  fgl_label_egress #(.NUM_LABELS(NL)) i_fgl_label_egress (
    .clk(clk), .rstN(rstN),
    .sAxisTdata(sTdata), .sAxisTvalid(sTvalid), .sAxisTlast(sTlast),
    .sAxisTready(sTready), .mAxisTdata(mTdata), .mAxisTvalid(mTvalid),
    .mAxisTlast(mTlast), .mAxisTready(mTready), .portFgl(portFgl),
    .portStrip(portStrip), .cfgValid(cfgValid), .cfgLabel(cfgLabel), .cfgVid(cfgVid)
  );

  function automatic byteQ macs();
    byteQ q;
    for (int i = 0; i < 12; i++) q.push_back(8'(8'h10 + i));
    return q;
  endfunction

  function automatic void addPayload(ref byteQ q, input int n);
    for (int i = 0; i < n; i++) q.push_back(8'(8'hA0 + i));
  endfunction

  function automatic byteQ mkVl(logic [3:0] pri, logic [11:0] vid, int n);
    byteQ q = macs();
    q.push_back(8'h81); q.push_back(8'h00);
    q.push_back({pri, vid[11:8]}); q.push_back(vid[7:0]);
    addPayload(q, n);
    return q;
  endfunction

  function automatic byteQ mkFgl(logic [3:0] hiPri, logic [11:0] hi, logic [3:0] loPri,
                                 logic [11:0] lo, int n, logic [15:0] et2);
    byteQ q = macs();
    q.push_back(8'h89); q.push_back(8'h3B);
    q.push_back({hiPri, hi[11:8]}); q.push_back(hi[7:0]);
    q.push_back(et2[15:8]); q.push_back(et2[7:0]);
    q.push_back({loPri, lo[11:8]}); q.push_back(lo[7:0]);
    addPayload(q, n);
    return q;
  endfunction

  function automatic byteQ expTag(logic [3:0] pri, logic [11:0] vid, int n);
    return mkVl(pri, vid, n);
  endfunction

  function automatic byteQ expBare(int n);
    byteQ q = macs();
    addPayload(q, n);
    return q;
  endfunction

  task automatic runFrame(input byteQ f, input bit bp);
    int ip = 0;
    int idle = 0;
    int cyc = 0;
    outQ.delete();
    lastCount = 0;
    lastPos = -1;
    while (1) begin
      @(negedge clk);
      if (ip < f.size()) begin
        sTvalid = 1'b1;
        sTdata = f[ip];
        sTlast = (ip == f.size() - 1);
      end else begin
        sTvalid = 1'b0;
        sTlast = 1'b0;
      end
      mTready = bp ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (mTvalid && mTready) begin
        outQ.push_back(mTdata);
        if (mTlast) begin
          lastCount++;
          lastPos = outQ.size() - 1;
        end
      end
      if (sTvalid && sTready) ip++;
      if (ip >= f.size()) idle++;
      if (idle > 30) break;
      cyc++;
      if (cyc > 3000) begin
        checks++; errors++;
        $display("FAIL frame hang: actual %0d bytes taken expected %0d", ip, f.size());
        break;
      end
    end
    sTvalid = 1'b0;
    sTlast = 1'b0;
    mTready = 1'b1;
  endtask

  task automatic checkOut(input byteQ exp, input string req);
    bit bad = (outQ.size() != exp.size());
    int at = -1;
    if (!bad) begin
      for (int i = 0; i < exp.size(); i++)
        if (outQ[i] !== exp[i] && at < 0) at = i;
      bad = (at >= 0);
    end
    checks++;
    if (bad) begin
      errors++;
      if (at >= 0)
        $display("FAIL %s: byte %0d actual %h expected %h", req, at, outQ[at], exp[at]);
      else
        $display("FAIL %s: length actual %0d expected %0d", req, outQ.size(), exp.size());
    end
    checks++;
    if (exp.size() == 0 ? (lastCount != 0)
                        : (lastCount != 1 || lastPos != exp.size() - 1)) begin
      errors++;
      $display("FAIL %s tlast: actual count %0d pos %0d expected pos %0d",
               req, lastCount, lastPos, exp.size() - 1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (mTvalid !== 1'b0 || sTready !== 1'b1) begin
      errors++;
      $display("FAIL R10: actual valid %b ready %b expected 0 1", mTvalid, sTready);
    end
  endtask

  task automatic t_vl_port();
    byteQ e;
    portFgl = 0; portStrip = 0;
    runFrame(mkVl(4'hA, 12'h064, 5), 0);
    checkOut(mkVl(4'hA, 12'h064, 5), "R1 R2 vlan frame unchanged");
    runFrame(mkFgl(4'h2, 12'h123, 4'hB, 12'h456, 5, 16'h893B), 0);
    checkOut(e, "R2 fgl frame dropped on vlan port");
  endtask

  task automatic t_fgl_pass();
    portFgl = 1; portStrip = 0;
    runFrame(mkFgl(4'h2, 12'h123, 4'hB, 12'h456, 6, 16'h893B), 0);
    checkOut(expTag(4'hB, 12'h0AB, 6), "R3 R5 tag rewrite");
    runFrame(mkFgl(4'hE, 12'h00F, 4'h5, 12'h00E, 3, 16'h893B), 0);
    checkOut(expTag(4'h5, 12'hF0E, 3), "R5 lowest index entry wins");
  endtask

  task automatic t_label_miss();
    byteQ e;
    portFgl = 1; portStrip = 0;
    runFrame(mkFgl(4'h2, 12'h123, 4'hB, 12'h457, 4, 16'h893B), 0);
    checkOut(e, "R3 high half only match dropped");
    runFrame(mkFgl(4'h2, 12'h124, 4'hB, 12'h456, 4, 16'h893B), 0);
    checkOut(e, "R3 low half only match dropped");
    runFrame(mkFgl(4'h2, 12'hABC, 4'hB, 12'h00F, 4, 16'h893B), 0);
    checkOut(e, "R3 invalid entry never matches");
  endtask

  task automatic t_strip();
    portFgl = 1; portStrip = 1;
    runFrame(mkFgl(4'h2, 12'h123, 4'hB, 12'h456, 7, 16'h893B), 0);
    checkOut(expBare(7), "R6 fgl strip 8 bytes shorter");
    portFgl = 0;
    runFrame(mkVl(4'h3, 12'h321, 7), 0);
    checkOut(expBare(7), "R6 vlan strip 4 bytes shorter");
    portStrip = 0;
  endtask

  task automatic t_rejects();
    byteQ e;
    byteQ other = macs();
    other.push_back(8'h08); other.push_back(8'h00);
    addPayload(other, 6);
    portFgl = 1; portStrip = 0;
    runFrame(mkVl(4'h1, 12'h0AB, 5), 0);
    checkOut(e, "R4 vlan frame dropped on fgl port");
    runFrame(mkFgl(4'h2, 12'h123, 4'hB, 12'h456, 5, 16'h8100), 0);
    checkOut(e, "R4 bad second marker dropped");
    runFrame(other, 0);
    checkOut(e, "R1 other ethertype dropped fgl mode");
    portFgl = 0;
    runFrame(other, 0);
    checkOut(e, "R1 other ethertype dropped vlan mode");
  endtask

  task automatic t_runt();
    byteQ e;
    byteQ r = macs();
    r.push_back(8'h89); r.push_back(8'h3B); r.push_back(8'h01);
    portFgl = 1; portStrip = 0;
    runFrame(r, 0);
    checkOut(e, "R7 runt discarded");
    runFrame(mkFgl(4'h2, 12'h123, 4'h7, 12'h456, 2, 16'h893B), 0);
    checkOut(expTag(4'h7, 12'h0AB, 2), "R7 frame after runt");
  endtask

  task automatic t_no_payload();
    portFgl = 1; portStrip = 0;
    runFrame(mkFgl(4'h2, 12'h123, 4'hC, 12'h456, 0, 16'h893B), 0);
    checkOut(expTag(4'hC, 12'h0AB, 0), "R8 header only tag");
    portStrip = 1;
    runFrame(mkFgl(4'h2, 12'h123, 4'hC, 12'h456, 0, 16'h893B), 0);
    checkOut(expBare(0), "R8 header only strip");
    portStrip = 0;
  endtask

  task automatic t_backpressure();
    portFgl = 1; portStrip = 0;
    runFrame(mkFgl(4'h2, 12'h123, 4'h9, 12'h456, 9, 16'h893B), 1);
    checkOut(expTag(4'h9, 12'h0AB, 9), "R9 fgl under stall");
    portFgl = 0;
    runFrame(mkVl(4'h6, 12'h7F1, 9), 1);
    checkOut(mkVl(4'h6, 12'h7F1, 9), "R9 vlan under stall");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfgLabel[0*24 +: 24] = 24'h123456; cfgVid[0*12 +: 12] = 12'h0AB; cfgValid[0] = 1'b1;
    cfgLabel[2*24 +: 24] = 24'hABC00F; cfgVid[2*12 +: 12] = 12'h222; cfgValid[2] = 1'b0;
    cfgLabel[3*24 +: 24] = 24'h00F00E; cfgVid[3*12 +: 12] = 12'hF0E; cfgValid[3] = 1'b1;
    cfgLabel[5*24 +: 24] = 24'h00F00E; cfgVid[5*12 +: 12] = 12'h555; cfgValid[5] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_vl_port();
    t_fgl_pass();
    t_label_miss();
    t_strip();
    t_rejects();
    t_runt();
    t_no_payload();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule